// File: doc/BRIEF.md
# Snooping write-through cache pair

This block holds two private level-one data caches, one for each of two cores. Both caches share a single bus to a common backing store that plays the part of the second level. Each core sends word reads and word writes and gets back the data, a hit flag and a code that names the cause of the access outcome. Every store is written to the backing store in the same transaction that updates the local line. The same transaction removes any copy of that block held by the other core's cache, so the other core never reads stale data.

Both caches are direct-mapped with two lines of eight 32-bit words, which gives 64 bytes per cache and 32-byte blocks. Each line keeps its tag after a snoop removes it, along with a flag that records the removal. Every miss can therefore be traced to its cause: the line was never filled, a different block occupies the slot, or the other core invalidated the block. Each core has saturating counters for read hits, write hits, compulsory misses, conflict misses, and coherence misses, with coherence misses split into reads and writes. Only one transaction is on the bus at a time, and core 0 wins when both cores ask in the same cycle.

Top module: `snoop_l1_pair`

## Requirements
- R1: A request address is a word address: bits [2:0] select the word in a block, bit [3] selects the cache line, and bits [6:4] form the tag. Two addresses that differ only in bit [3] use different lines and can both be resident.
- R2: A request is taken at the clock edge where both `req_valid[c]` and `req_ready[c]` are high. `req_ready` goes high only when no transaction is in flight. `resp_valid[c]` is high for exactly the one cycle that follows the second edge after acceptance.
- R3: When both cores request in the same cycle, core 0 is accepted first. Core 1 is accepted two edges later, and its access is looked up after core 0's write has taken effect.
- R4: A read returns the current word of the shared store, including words written by either core. A write updates the shared store at once and returns the written word on `resp_rdata`.
- R5: A write removes the other cache's line only if that line is valid and holds the same block. A line in the other cache that holds a different block stays resident.
- R6: `resp_class` is encoded as 0 = read hit, 1 = write hit, 2 = compulsory miss, 3 = conflict miss, 4 = coherence miss. `resp_hit` is 1 exactly for codes 0 and 1.
- R7: A miss on a line that has not been filled since reset is a compulsory miss.
- R8: A miss on a line that was filled is a conflict miss, unless R9 applies. This covers a valid line with a different tag and a snooped line whose kept tag differs.
- R9: A miss on a line that the other core's write invalidated, and whose kept tag matches the request, is a coherence miss. Reads and writes are counted in separate counters.
- R10: A write miss allocates the block: the block is fetched, the word is merged, and a later access to the same block hits.
- R11: Each counter increases by one per access of its class on its core, saturates at all ones and never wraps.
- R12: After reset all counters are zero, no response is pending, no line is valid, and the shared store reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-core request present |
| req_ready | output | 2 | Per-core request accepted this cycle |
| req_write | input | 2 | Per-core write (1) or read (0) |
| req_addr | input | 2x7 | Per-core word address |
| req_wdata | input | 2x32 | Per-core write data |
| resp_valid | output | 2 | Per-core response strobe |
| resp_hit | output | 2 | Per-core hit flag |
| resp_class | output | 2x3 | Per-core outcome code |
| resp_rdata | output | 2x32 | Per-core returned word |
| cnt_rd_hit | output | 2xCNT_W | Read hit count |
| cnt_wr_hit | output | 2xCNT_W | Write hit count |
| cnt_compulsory | output | 2xCNT_W | Compulsory miss count |
| cnt_conflict | output | 2xCNT_W | Conflict miss count |
| cnt_coh_rd | output | 2xCNT_W | Coherence read miss count |
| cnt_coh_wr | output | 2xCNT_W | Coherence write miss count |

## Verification
Each response, with its data, hit flag and class, appears in the cycle after the second rising edge that follows acceptance. The counters of the responding core change at that same edge. The bench records the cycle number at acceptance in each queued item. The monitor samples on the falling edge and requires the response to arrive exactly two edges later, and it compares the counters at that same sample. For simultaneous requests, it also checks that core 1 is accepted two edges after core 0 and that core 0 responds first.

// File: rtl/snoopl1_pkg.sv
package snoopl1_pkg;
  localparam int NCORES = 2;
  localparam int CORE_W = 1;

  typedef enum logic [2:0] {
    CLS_RD_HIT     = 3'd0,
    CLS_WR_HIT     = 3'd1,
    CLS_COMPULSORY = 3'd2,
    CLS_CONFLICT   = 3'd3,
    CLS_COHERENCE  = 3'd4
  } access_cls_e;
endpackage

// File: rtl/snoop_bus_arb.sv
module snoop_bus_arb
  import snoopl1_pkg::*;
(
  input  logic [NCORES-1:0] req,
  input  logic              busy,
  output logic [NCORES-1:0] grant,
  output logic              gnt_any,
  output logic [CORE_W-1:0] gnt_id
);
  // fixed priority: lowest core index wins, nothing granted while busy
  always_comb begin
    grant   = '0;
    gnt_any = 1'b0;
    gnt_id  = '0;
    if (!busy) begin
      for (int i = 0; i < NCORES; i++) begin
        if (req[i] && !gnt_any) begin
          grant[i] = 1'b1;
          gnt_any  = 1'b1;
          gnt_id   = i[CORE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/snoop_l1_array.sv
module snoop_l1_array #(
  parameter int LINES = 2,
  parameter int IDX_W = 1,
  parameter int TAG_W = 3,
  parameter int BLK_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_filled,
  output logic             rd_killed,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_block,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [BLK_W-1:0] fill_block,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag
);
  logic [LINES-1:0] valid_q, filled_q, killed_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [BLK_W-1:0] data_q [LINES];

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[l]  <= 1'b0;
          filled_q[l] <= 1'b0;
          killed_q[l] <= 1'b0;
          tag_q[l]    <= '0;
        end else if (fill_en && fill_idx == IDX_W'(l)) begin
          valid_q[l]  <= 1'b1;
          filled_q[l] <= 1'b1;
          killed_q[l] <= 1'b0;
          tag_q[l]    <= fill_tag;
        end else if (inv_en && inv_idx == IDX_W'(l) &&
                     valid_q[l] && tag_q[l] == inv_tag) begin
          valid_q[l]  <= 1'b0;
          killed_q[l] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (fill_en) data_q[fill_idx] <= fill_block;
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_filled = filled_q[rd_idx];
  assign rd_killed = killed_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_block  = data_q[rd_idx];
endmodule

// File: rtl/snoop_shared_store.sv
module snoop_shared_store #(
  parameter int BLOCKS     = 16,
  parameter int BLK_ADDR_W = 4,
  parameter int BLK_W      = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [BLK_ADDR_W-1:0] rd_blk,
  output logic [BLK_W-1:0]      rd_block,
  input  logic                  wr_en,
  input  logic [BLK_ADDR_W-1:0] wr_blk,
  input  logic [BLK_W-1:0]      wr_block
);
  logic [BLK_W-1:0]  mem [BLOCKS];
  logic [BLK_W-1:0]  raw_q;
  logic [BLOCKS-1:0] written_q;
  logic              raw_ok_q;

  // plain array with no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_blk] <= wr_block;
    if (rd_en) raw_q <= mem[rd_blk];
  end

  // per-block written flags make never-written blocks read as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      raw_ok_q  <= 1'b0;
    end else begin
      if (wr_en) written_q[wr_blk] <= 1'b1;
      if (rd_en) raw_ok_q <= written_q[rd_blk];
    end
  end

  assign rd_block = raw_ok_q ? raw_q : '0;
endmodule

// File: rtl/snoop_access_counters.sv
module snoop_access_counters
  import snoopl1_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inc_en,
  input  access_cls_e cls,
  input  logic        is_write,
  output logic [CNT_W-1:0] rd_hit,
  output logic [CNT_W-1:0] wr_hit,
  output logic [CNT_W-1:0] compulsory,
  output logic [CNT_W-1:0] conflict,
  output logic [CNT_W-1:0] coh_rd,
  output logic [CNT_W-1:0] coh_wr
);
  localparam int NCNT = 6;
  logic [NCNT-1:0]  bump;
  logic [CNT_W-1:0] cnt_q [NCNT];

  always_comb begin
    bump = '0;
    if (inc_en) begin
      case (cls)
        CLS_RD_HIT:     bump[0] = 1'b1;
        CLS_WR_HIT:     bump[1] = 1'b1;
        CLS_COMPULSORY: bump[2] = 1'b1;
        CLS_CONFLICT:   bump[3] = 1'b1;
        CLS_COHERENCE:  if (is_write) bump[5] = 1'b1; else bump[4] = 1'b1;
        default:        bump = '0;
      endcase
    end
  end

  generate
    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) cnt_q[k] <= '0;
        else if (bump[k] && cnt_q[k] != {CNT_W{1'b1}}) cnt_q[k] <= cnt_q[k] + 1'b1;
      end
    end
  endgenerate

  assign rd_hit     = cnt_q[0];
  assign wr_hit     = cnt_q[1];
  assign compulsory = cnt_q[2];
  assign conflict   = cnt_q[3];
  assign coh_rd     = cnt_q[4];
  assign coh_wr     = cnt_q[5];
endmodule

// File: rtl/snoop_l1_pair.sv
module snoop_l1_pair
  import snoopl1_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int BLK_WORDS  = 8,
  parameter int LINES      = 2,
  parameter int MEM_BLOCKS = 16,
  parameter int CNT_W      = 32,
  localparam int OFF_W      = $clog2(BLK_WORDS),
  localparam int BLK_ADDR_W = $clog2(MEM_BLOCKS),
  localparam int ADDR_W     = OFF_W + BLK_ADDR_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NCORES-1:0]                req_valid,
  output logic [NCORES-1:0]                req_ready,
  input  logic [NCORES-1:0]                req_write,
  input  logic [NCORES-1:0][ADDR_W-1:0]    req_addr,
  input  logic [NCORES-1:0][WORD_W-1:0]    req_wdata,
  output logic [NCORES-1:0]                resp_valid,
  output logic [NCORES-1:0]                resp_hit,
  output logic [NCORES-1:0][2:0]           resp_class,
  output logic [NCORES-1:0][WORD_W-1:0]    resp_rdata,
  output logic [NCORES-1:0][CNT_W-1:0]     cnt_rd_hit,
  output logic [NCORES-1:0][CNT_W-1:0]     cnt_wr_hit,
  output logic [NCORES-1:0][CNT_W-1:0]     cnt_compulsory,
  output logic [NCORES-1:0][CNT_W-1:0]     cnt_conflict,
  output logic [NCORES-1:0][CNT_W-1:0]     cnt_coh_rd,
  output logic [NCORES-1:0][CNT_W-1:0]     cnt_coh_wr
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = BLK_ADDR_W - IDX_W;
  localparam int BLK_W = BLK_WORDS * WORD_W;

  // ---------------- bus grant ----------------
  logic              s1_vld;
  logic              gnt_any;
  logic [CORE_W-1:0] gnt_id;

  snoop_bus_arb u_arb (
    .req     (req_valid),
    .busy    (s1_vld),
    .grant   (req_ready),
    .gnt_any (gnt_any),
    .gnt_id  (gnt_id)
  );

  // ---------------- stage 1 request register ----------------
  logic [CORE_W-1:0] s1_core;
  logic              s1_we;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s1_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_core  <= '0;
      s1_we    <= 1'b0;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_vld <= gnt_any;
      if (gnt_any) begin
        s1_core  <= gnt_id;
        s1_we    <= req_write[gnt_id];
        s1_addr  <= req_addr[gnt_id];
        s1_wdata <= req_wdata[gnt_id];
      end
    end
  end

  logic [OFF_W-1:0]      s1_off;
  logic [BLK_ADDR_W-1:0] s1_blk;
  logic [IDX_W-1:0]      s1_idx;
  logic [TAG_W-1:0]      s1_tag;

  assign s1_off = s1_addr[OFF_W-1:0];
  assign s1_blk = s1_addr[ADDR_W-1:OFF_W];
  assign s1_idx = s1_blk[IDX_W-1:0];
  assign s1_tag = s1_blk[BLK_ADDR_W-1:IDX_W];

  // ---------------- shared store ----------------
  logic [BLK_W-1:0] mem_block;
  logic [BLK_W-1:0] new_block;

  snoop_shared_store #(
    .BLOCKS     (MEM_BLOCKS),
    .BLK_ADDR_W (BLK_ADDR_W),
    .BLK_W      (BLK_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (gnt_any),
    .rd_blk   (req_addr[gnt_id][ADDR_W-1:OFF_W]),
    .rd_block (mem_block),
    .wr_en    (s1_vld && s1_we),
    .wr_blk   (s1_blk),
    .wr_block (new_block)
  );

  // ---------------- private caches ----------------
  logic [NCORES-1:0] lk_valid, lk_filled, lk_killed;
  logic [TAG_W-1:0]  lk_tag   [NCORES];
  logic [BLK_W-1:0]  lk_block [NCORES];

  generate
    for (genvar c = 0; c < NCORES; c++) begin : g_core
      snoop_l1_array #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
      ) u_l1 (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (s1_idx),
        .rd_valid   (lk_valid[c]),
        .rd_filled  (lk_filled[c]),
        .rd_killed  (lk_killed[c]),
        .rd_tag     (lk_tag[c]),
        .rd_block   (lk_block[c]),
        .fill_en    (s1_vld && s1_core == CORE_W'(c)),
        .fill_idx   (s1_idx),
        .fill_tag   (s1_tag),
        .fill_block (new_block),
        .inv_en     (s1_vld && s1_we && s1_core != CORE_W'(c)),
        .inv_idx    (s1_idx),
        .inv_tag    (s1_tag)
      );
    end
  endgenerate

  // ---------------- lookup and classification ----------------
  logic        sel_valid, sel_filled, sel_killed, tag_eq, hit;
  access_cls_e cls;
  logic [WORD_W-1:0] out_word;

  assign sel_valid  = lk_valid[s1_core];
  assign sel_filled = lk_filled[s1_core];
  assign sel_killed = lk_killed[s1_core];
  assign tag_eq     = lk_tag[s1_core] == s1_tag;
  assign hit        = sel_valid && tag_eq;

  always_comb begin
    if (hit)                      cls = s1_we ? CLS_WR_HIT : CLS_RD_HIT;
    else if (!sel_filled)         cls = CLS_COMPULSORY;
    else if (sel_killed && tag_eq) cls = CLS_COHERENCE;
    else                          cls = CLS_CONFLICT;
  end

  always_comb begin
    new_block = hit ? lk_block[s1_core] : mem_block;
    out_word  = '0;
    for (int w = 0; w < BLK_WORDS; w++) begin
      if (s1_we && s1_off == OFF_W'(w)) new_block[w*WORD_W +: WORD_W] = s1_wdata;
    end
    for (int w = 0; w < BLK_WORDS; w++) begin
      if (s1_off == OFF_W'(w)) out_word = new_block[w*WORD_W +: WORD_W];
    end
  end

  // ---------------- responses and counters ----------------
  generate
    for (genvar c = 0; c < NCORES; c++) begin : g_resp
      logic mine;
      assign mine = s1_vld && s1_core == CORE_W'(c);

      always_ff @(posedge clk) begin
        if (rst) begin
          resp_valid[c] <= 1'b0;
          resp_hit[c]   <= 1'b0;
          resp_class[c] <= 3'd0;
          resp_rdata[c] <= '0;
        end else begin
          resp_valid[c] <= mine;
          if (mine) begin
            resp_hit[c]   <= hit;
            resp_class[c] <= cls;
            resp_rdata[c] <= out_word;
          end
        end
      end

      snoop_access_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc_en     (mine),
        .cls        (cls),
        .is_write   (s1_we),
        .rd_hit     (cnt_rd_hit[c]),
        .wr_hit     (cnt_wr_hit[c]),
        .compulsory (cnt_compulsory[c]),
        .conflict   (cnt_conflict[c]),
        .coh_rd     (cnt_coh_rd[c]),
        .coh_wr     (cnt_coh_wr[c])
      );
    end
  endgenerate
endmodule

// File: rtl/snoop_pair_checker.sv
module snoop_pair_checker
  import snoopl1_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NCORES-1:0]            req_valid,
  input logic [NCORES-1:0]            req_ready,
  input logic [NCORES-1:0]            resp_valid,
  input logic [NCORES-1:0]            resp_hit,
  input logic [NCORES-1:0][2:0]       resp_class,
  input logic [NCORES-1:0][CNT_W-1:0] cnt_rd_hit,
  input logic [NCORES-1:0][CNT_W-1:0] cnt_coh_rd
);
  // R2: at most one core accepted per cycle
  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  // R2: an acceptance blocks the bus for the following cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (|(req_valid & req_ready)) |=> (req_ready == '0));

  // R3: core 0 wins a simultaneous request
  a_r3_core0_first: assert property (@(posedge clk) disable iff (rst)
    (&req_valid && |req_ready) |-> req_ready[0]);

  // R2: at most one response per cycle
  a_r2_one_resp: assert property (@(posedge clk) disable iff (rst)
    $onehot0(resp_valid));

  generate
    for (genvar c = 0; c < NCORES; c++) begin : g_chk
      // R2: response due two edges after acceptance
      a_r2_resp_due: assert property (@(posedge clk) disable iff (rst)
        (req_valid[c] && req_ready[c]) |-> ##2 resp_valid[c]);

      // R6: hit flag agrees with the outcome code
      a_r6_hit_code: assert property (@(posedge clk) disable iff (rst)
        resp_valid[c] |-> (resp_hit[c] == (resp_class[c] <= 3'd1)) && (resp_class[c] <= 3'd4));

      // R11: counters move up by at most one and never wrap
      a_r11_rd_hit_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_hit[c] >= $past(cnt_rd_hit[c])) &&
        (cnt_rd_hit[c] - $past(cnt_rd_hit[c]) <= 1));

      a_r9_coh_rd_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_coh_rd[c] >= $past(cnt_coh_rd[c])) &&
        (cnt_coh_rd[c] - $past(cnt_coh_rd[c]) <= 1));
    end
  endgenerate
endmodule

bind snoop_l1_pair snoop_pair_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_class (resp_class),
  .cnt_rd_hit (cnt_rd_hit),
  .cnt_coh_rd (cnt_coh_rd)
);

// File: tb/sim_snoop_l1_pair.sv
module sim_snoop_l1_pair;
  import snoopl1_pkg::*;

  localparam int CNT_W  = 4;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 32;
  localparam int SAT    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]             req_valid = '0;
  logic [1:0]             req_ready;
  logic [1:0]             req_write = '0;
  logic [1:0][ADDR_W-1:0] req_addr  = '0;
  logic [1:0][WORD_W-1:0] req_wdata = '0;
  logic [1:0]             resp_valid, resp_hit;
  logic [1:0][2:0]        resp_class;
  logic [1:0][WORD_W-1:0] resp_rdata;
  logic [1:0][CNT_W-1:0]  c_rh, c_wh, c_cp, c_cf, c_cr, c_cw;

  snoop_l1_pair #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_class(resp_class),
    .resp_rdata(resp_rdata),
    .cnt_rd_hit(c_rh), .cnt_wr_hit(c_wh), .cnt_compulsory(c_cp),
    .cnt_conflict(c_cf), .cnt_coh_rd(c_cr), .cnt_coh_wr(c_cw)
  );

  always #10 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  typedef struct { bit we; int addr; logic [31:0] d; longint acc; } item_t;
  item_t q0[$], q1[$];
  logic [31:0] mem_m [128];
  bit mv [2][2], mf [2][2], mk [2][2];
  int mt [2][2];
  int ec [2][6];
  int last_cls [2];
  int resp_seq[$];
  longint last_acc [2];

  initial begin
    for (int i = 0; i < 128; i++) mem_m[i] = '0;
  end

  function automatic void bump(int c, int k);
    if (ec[c][k] < SAT) ec[c][k]++;
  endfunction

  // ---------------- driver ----------------
  task automatic issue(int c, bit we, int addr, logic [31:0] d);
    item_t it;
    @(negedge clk);
    req_valid[c] = 1'b1; req_write[c] = we;
    req_addr[c] = addr[ADDR_W-1:0]; req_wdata[c] = d;
    #1;
    while (!req_ready[c]) begin @(negedge clk); #1; end
    it.we = we; it.addr = addr; it.d = d; it.acc = cyc;
    last_acc[c] = cyc;
    if (c == 0) q0.push_back(it); else q1.push_back(it);
    @(posedge clk); #1;
    req_valid[c] = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        if (resp_valid[c]) begin
          item_t it;
          int blk, idx, tg, o, ecls, ehit;
          logic [31:0] edata;
          string rq;
          if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
            chk(0, "R2", "unexpected response core", c, -1);
          end else begin
            it = (c == 0) ? q0.pop_front() : q1.pop_front();
            resp_seq.push_back(c);
            o = 1 - c;
            blk = it.addr >> 3; idx = blk & 1; tg = blk >> 1;
            ehit = mv[c][idx] && mt[c][idx] == tg;
            if (ehit) ecls = it.we ? 1 : 0;
            else if (!mf[c][idx]) ecls = 2;
            else if (mk[c][idx] && mt[c][idx] == tg) ecls = 4;
            else ecls = 3;
            mv[c][idx] = 1; mf[c][idx] = 1; mk[c][idx] = 0; mt[c][idx] = tg;
            if (it.we) begin
              mem_m[it.addr] = it.d;
              if (mv[o][idx] && mt[o][idx] == tg) begin mv[o][idx] = 0; mk[o][idx] = 1; end
            end
            edata = mem_m[it.addr];
            case (ecls)
              0: bump(c, 0);
              1: bump(c, 1);
              2: bump(c, 2);
              3: bump(c, 3);
              default: bump(c, it.we ? 5 : 4);
            endcase
            case (ecls)
              2: rq = "R7";
              3: rq = "R8";
              4: rq = "R9";
              default: rq = "R6";
            endcase
            last_cls[c] = ecls;
            chk(cyc == it.acc + 2, "R2", "response cycle", cyc, it.acc + 2);
            chk(resp_class[c] == 3'(ecls), rq, "class", resp_class[c], ecls);
            chk(resp_hit[c] == ehit[0], "R6", "hit flag", resp_hit[c], ehit);
            chk(resp_rdata[c] == edata, "R4", "data", resp_rdata[c], edata);
            chk(c_rh[c] == CNT_W'(ec[c][0]), "R11", "read hit count", c_rh[c], ec[c][0]);
            chk(c_wh[c] == CNT_W'(ec[c][1]), "R11", "write hit count", c_wh[c], ec[c][1]);
            chk(c_cp[c] == CNT_W'(ec[c][2]), "R7", "compulsory count", c_cp[c], ec[c][2]);
            chk(c_cf[c] == CNT_W'(ec[c][3]), "R8", "conflict count", c_cf[c], ec[c][3]);
            chk(c_cr[c] == CNT_W'(ec[c][4]), "R9", "coherence read count", c_cr[c], ec[c][4]);
            chk(c_cw[c] == CNT_W'(ec[c][5]), "R9", "coherence write count", c_cw[c], ec[c][5]);
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(resp_valid == 2'b00, "R12", "no response after reset", resp_valid, 0);
    chk(req_ready == 2'b00, "R12", "ready idle", req_ready, 0);
    chk(c_rh == '0 && c_cp == '0 && c_cr == '0 && c_cw == '0, "R12", "counters zero", c_rh, 0);

    issue(0, 0, 0, 0);            // compulsory, reads zero store (R12)
    drain();
    chk(last_cls[0] == 2, "R12", "first access compulsory", last_cls[0], 2);
    issue(0, 0, 1, 0);            // read hit
    issue(0, 1, 2, 32'hA5A5_0002); // write hit
    issue(1, 0, 2, 0);            // compulsory, sees write-through data (R4)
    issue(0, 1, 3, 32'h0000_B003); // invalidates core 1 line 0
    issue(1, 0, 3, 0);            // coherence read miss (R9)
    issue(0, 1, 5, 32'h0000_C005); // invalidates core 1 again
    issue(1, 1, 6, 32'h0000_D006); // coherence write miss (R9)
    issue(0, 0, 16, 0);           // conflict on line 0 (R8)
    issue(0, 0, 0, 0);            // conflict back (R8)
    drain();
    chk(last_cls[0] == 3, "R8", "replaced line gives conflict", last_cls[0], 3);

    // R1: line 1 independent of line 0
    issue(1, 0, 8, 0);            // compulsory on line 1
    issue(1, 0, 2, 0);            // line 0 still holds block 0: hit
    drain();
    chk(last_cls[1] == 0, "R1", "two lines resident", last_cls[1], 0);

    // R3: simultaneous write by core 0 and read by core 1 of block 0
    resp_seq.delete();
    fork
      issue(0, 1, 0, 32'h1234_5678);
      issue(1, 0, 0, 0);
    join
    drain();
    chk(resp_seq.size() == 2 && resp_seq[0] == 0, "R3", "core 0 served first", resp_seq.size() > 0 ? resp_seq[0] : -1, 0);
    chk(last_acc[1] == last_acc[0] + 2, "R3", "core 1 accepted later", last_acc[1] - last_acc[0], 2);
    chk(last_cls[1] == 4, "R3", "core 1 sees invalidate first", last_cls[1], 4);

    // R10: write miss allocates
    issue(0, 1, 40, 32'hFEED_0040); // block 5, line 1, never filled on core 0
    drain();
    chk(last_cls[0] == 2, "R10", "write miss compulsory", last_cls[0], 2);
    issue(0, 0, 41, 0);
    drain();
    chk(last_cls[0] == 0, "R10", "allocated block hits", last_cls[0], 0);

    // R5: write to other block on same line leaves core 1 line intact
    issue(0, 1, 42, 32'h0000_0042);
    issue(1, 0, 9, 0);
    drain();
    chk(last_cls[1] == 0, "R5", "non-matching block kept", last_cls[1], 0);

    // R11: saturation of core 1 read hits
    for (int i = 0; i < 20; i++) issue(1, 0, 8 + (i % 8), 0);
    drain();
    chk(c_rh[1] == CNT_W'(SAT), "R11", "read hit saturates", c_rh[1], SAT);
    chk(q0.size() == 0 && q1.size() == 0, "R2", "all responses seen", q0.size() + q1.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule